// File: doc/BRIEF.md
# UART Sleep and Receive-Line Wake Controller

This controller decides when a UART may drop into its low-power sleep state and when it has to leave it. Logic around it raises `sleep_req` when sleep is enabled and the UART has nothing else to do. The controller then looks at the receive line and at a sensitivity mode bit before it sets `asleep`. It also watches for the conditions that end sleep.

Two receive-line policies are available. In level mode, a low receive line stops sleep from starting, and a low line wakes a sleeping UART. In edge mode, sleep may start whatever the line level is, and any change of the line ends it. A host-access input also ends sleep in either mode. Every wake raises `wake_pulse` for one cycle.

The receive pin is asynchronous and passes through a two-flop synchronizer before it is used.

Top module: `uart_sleep_wake`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `asleep` and `wake_pulse` are both 0. Reset leaves the controller armed, so a request that is held high can put it to sleep.
- R2: When the controller is awake and armed, `sleep_req` is 1, `host_wake` is 0, and either `edge_mode` is 1 or the synchronized receive line is 1, `asleep` is 1 after the next clock edge.
- R3: In level mode (`edge_mode` = 0), a sleeping controller wakes when the receive line is low. `asleep` falls and `wake_pulse` rises on the third rising clock edge after the pin falls, two of those edges being the synchronizer.
- R4: In level mode, `asleep` stays 0 for as long as the synchronized receive line is low, even with `sleep_req` held at 1.
- R5: When `host_wake` is 1 while asleep, in either mode, the next edge clears `asleep` and raises `wake_pulse`.
- R6: Once sleep has been entered, it can be entered again only after `sleep_req` has been seen at 0. A request held high through a wake does not put the controller back to sleep.
- R7: In edge mode (`edge_mode` = 1), sleep is entered even while the receive line is low.
- R8: In edge mode, a sleeping controller wakes on a rising or a falling change of the receive line. The timing is the same three edges as R3.
- R9: In edge mode, entering sleep raises no wake, and `asleep` stays 1 while the line holds steady at either level.
- R10: If `sleep_req` falls while asleep and there is no wake condition, the next edge clears `asleep` without a `wake_pulse`.
- R11: `wake_pulse` is 1 only in the cycle right after `asleep` falls because of a wake, and it never lasts two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Sleep allowed (enabled and otherwise idle) |
| rx_pin | input | 1 | Asynchronous receive line |
| edge_mode | input | 1 | 0 = level-sensitive, 1 = edge-sensitive |
| host_wake | input | 1 | Host access wake |
| asleep | output | 1 | Sleep state flag |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
The bench aims at the entry instant in edge mode with the line low. A design that did not load its edge history on entry would wake at once. It also holds `sleep_req` high through a wake: a controller missing the re-arm rule would fall straight back to sleep. A level-mode design that ignored the inhibit would sleep with the line low, and one that counted synchronizer stages wrong would produce the wake one cycle early or late. Finally, it drops the request while asleep to catch a design that wrongly pulses on that exit.

// File: rtl/uart_sleep_wake.sv
module uart_sleep_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic rx_pin,
  input  logic edge_mode,
  input  logic host_wake,
  output logic asleep,
  output logic wake_pulse
);

  logic [SYNC_STAGES-1:0] rx_chain;
  logic rx_now;
  logic rx_prev;
  logic armed;
  logic rx_wake;
  logic do_wake;
  logic do_enter;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_chain <= '1;
    else        rx_chain <= {rx_chain[SYNC_STAGES-2:0], rx_pin};
  end

  assign rx_now   = rx_chain[SYNC_STAGES-1];
  assign rx_wake  = edge_mode ? (rx_now != rx_prev) : !rx_now;
  assign do_wake  = asleep && (host_wake || rx_wake);
  assign do_enter = !asleep && armed && sleep_req && !host_wake && (edge_mode || rx_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      wake_pulse <= 1'b0;
      armed      <= 1'b1;
      rx_prev    <= 1'b1;
    end else begin
      rx_prev    <= rx_now;
      wake_pulse <= do_wake;
      if (do_wake || (asleep && !sleep_req)) asleep <= 1'b0;
      else if (do_enter)                     asleep <= 1'b1;
      if (!sleep_req)    armed <= 1'b1;
      else if (do_enter) armed <= 1'b0;
    end
  end

  assert_level_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !edge_mode && !rx_now) |=> !asleep);

  assert_level_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !edge_mode && !rx_now) |=> (!asleep && wake_pulse));

  assert_host_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && host_wake) |=> (!asleep && wake_pulse));

  assert_no_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && sleep_req) |=> !asleep);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_pulse_on_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(asleep) && !asleep));

  assert_drop_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !sleep_req && !host_wake && !rx_wake) |=> (!asleep && !wake_pulse));

endmodule

// File: tb/uart_sleep_wake_bench.sv
module uart_sleep_wake_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic rx_pin = 1'b1;
  logic edge_mode = 1'b0;
  logic host_wake = 1'b0;
  logic asleep, wake_pulse;

  typedef struct {
    int    at;
    logic  asl;
    logic  wk;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_sleep_wake u_uart_sleep_wake (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .rx_pin(rx_pin),
    .edge_mode(edge_mode), .host_wake(host_wake),
    .asleep(asleep), .wake_pulse(wake_pulse)
  );

  task automatic expect_in(input int d, input logic a, input logic w, input string tag);
    exp_t e;
    e.at = cyc + d; e.asl = a; e.wk = w; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (asleep !== e.asl || wake_pulse !== e.wk) begin
        errors++;
        $display("FAIL %s cycle %0d: asleep=%b wake=%b expected asleep=%b wake=%b",
                 e.tag, cyc, asleep, wake_pulse, e.asl, e.wk);
      end
    end
  end

  initial begin
    step(1);
    expect_in(1, 0, 0, "R1");
    step(2);
    rst_n = 1'b1;
    expect_in(1, 0, 0, "R1");
    step(4);

    sleep_req = 1'b1;
    expect_in(1, 1, 0, "R2");
    step(2);
    rx_pin = 1'b0;
    expect_in(2, 1, 0, "R3");
    expect_in(3, 0, 1, "R3");
    expect_in(4, 0, 0, "R11");
    step(4);
    rx_pin = 1'b1;
    step(6);
    expect_in(1, 0, 0, "R6");
    step(2);

    sleep_req = 1'b0;
    step(1);
    rx_pin = 1'b0;
    step(3);
    sleep_req = 1'b1;
    expect_in(1, 0, 0, "R4");
    expect_in(5, 0, 0, "R4");
    step(5);
    rx_pin = 1'b1;
    expect_in(2, 0, 0, "R4");
    expect_in(3, 1, 0, "R2");
    step(4);
    host_wake = 1'b1;
    expect_in(1, 0, 1, "R5");
    step(1);
    host_wake = 1'b0;
    expect_in(1, 0, 0, "R11");
    step(2);

    sleep_req = 1'b0;
    edge_mode = 1'b1;
    rx_pin = 1'b0;
    step(4);
    sleep_req = 1'b1;
    expect_in(1, 1, 0, "R7");
    expect_in(2, 1, 0, "R9");
    expect_in(6, 1, 0, "R9");
    step(6);
    rx_pin = 1'b1;
    expect_in(2, 1, 0, "R8");
    expect_in(3, 0, 1, "R8");
    expect_in(4, 0, 0, "R11");
    step(5);

    sleep_req = 1'b0;
    step(1);
    sleep_req = 1'b1;
    expect_in(1, 1, 0, "R9");
    expect_in(5, 1, 0, "R9");
    step(5);
    rx_pin = 1'b0;
    expect_in(3, 0, 1, "R8");
    step(5);

    sleep_req = 1'b0;
    step(1);
    sleep_req = 1'b1;
    expect_in(1, 1, 0, "R7");
    step(3);
    host_wake = 1'b1;
    expect_in(1, 0, 1, "R5");
    step(1);
    host_wake = 1'b0;
    step(2);

    sleep_req = 1'b0;
    step(1);
    sleep_req = 1'b1;
    expect_in(1, 1, 0, "R2");
    step(3);
    sleep_req = 1'b0;
    expect_in(1, 0, 0, "R10");
    expect_in(2, 0, 0, "R10");
    step(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 5000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule